// File: doc/BRIEF.md
# Per-Block Write-Protect State Controller

This block keeps a protection state for each erase block of a flash array and updates it from a two-write command pair. The first write, byte 0x60, arms the controller. The second write carries an action byte and the number of the block it targets. The stored state is given to the program/erase path as a per-block write-protect bit. The same path asks for permission through a request port. The controller refuses writes to protected blocks and reports a lock error on status bit 1.

Each block is in one of three states: unlocked, locked or locked-down. An unlock action cannot free a locked-down block; only reset clears that state. If the second write of a pair is not a recognised action, the controller pulses a sequence-error flag, which the status logic maps onto bits 4 and 5. Commands that do not begin with 0x60 belong to other parts of the chip, and this block ignores them.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset, every block reads as locked (state code 2'b01, where bit 0 means locked and bit 1 means locked-down), and the controller is not armed.
- R2: A write of 0x01 that follows the 0x60 setup write puts the addressed block in code 2'b01. If that block is locked-down, it stays at code 2'b11.
- R3: A write of 0xD0 that follows the setup write sets the addressed block to 2'b00 (unlocked), provided the block is not locked-down.
- R4: A write of 0x2F that follows the setup write sets the addressed block to 2'b11 (locked-down).
- R5: A 0xD0 action aimed at a locked-down block leaves every block state unchanged.
- R6: If the write after the setup carries any other byte, including 0x60, `seq_err` is high for exactly the next cycle. No block state changes, and the controller is disarmed.
- R7: A write that neither follows a setup nor carries 0x60 changes no block state and raises no flag.
- R8: `pe_req` aimed at a block whose code has bit 0 set gives a one-cycle `lock_err` pulse in the next cycle. A request aimed at an unlocked block gives a one-cycle `pe_ok` pulse instead. The two are never high together.
- R9: When a program/erase request and a lock action arrive in the same cycle, the request is judged on the block state from before that action.
- R10: `qry_code` and `qry_wp` show, with no clock delay, the state of block `qry_blk`. `qry_wp` equals bit 0 of that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_blk | input | BW | Block number taken from the write address |
| pe_req | input | 1 | Program/erase permission request |
| pe_blk | input | BW | Block targeted by the request |
| qry_blk | input | BW | Block whose state is shown |
| qry_code | output | 2 | State of the queried block: bit 0 locked, bit 1 locked-down |
| qry_wp | output | 1 | Write-protect for the queried block |
| pe_ok | output | 1 | Request accepted (one-cycle pulse) |
| lock_err | output | 1 | Request refused, status bit 1 (one-cycle pulse) |
| seq_err | output | 1 | Bad action byte, status bits 4 and 5 (one-cycle pulse) |

## Verification
A program/erase permission check and a lock-state change can fall in the same clock edge, and they may even target the same block. The bench provokes this with directed cases that unlock or lock-down a block while a request names that block. It also produces the collision in random traffic, where the request block often equals the command block. The expected verdict comes from the bench model's state from before the edge, so any design that lets the new state reach the verdict early shows up as a miscompare on `pe_ok` or `lock_err`.

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl #(
  parameter int NBLK = 16,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_data,
  input  logic [BW-1:0] cmd_blk,
  input  logic          pe_req,
  input  logic [BW-1:0] pe_blk,
  input  logic [BW-1:0] qry_blk,
  output logic [1:0]    qry_code,
  output logic          qry_wp,
  output logic          pe_ok,
  output logic          lock_err,
  output logic          seq_err
);
  localparam logic [7:0] OP_ARM  = 8'h60;
  localparam logic [7:0] OP_LOCK = 8'h01;
  localparam logic [7:0] OP_FREE = 8'h D0;
  localparam logic [7:0] OP_PIN  = 8'h2F;

  logic [1:0] lk [NBLK];
  logic       armed;

  wire act      = cmd_we & armed;
  wire op_valid = (cmd_data == OP_LOCK) | (cmd_data == OP_FREE) | (cmd_data == OP_PIN);

  assign qry_code = lk[qry_blk];
  assign qry_wp   = qry_code[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      seq_err  <= 1'b0;
      pe_ok    <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      if (cmd_we) armed <= !armed && (cmd_data == OP_ARM);
      seq_err  <= act && !op_valid;
      pe_ok    <= pe_req && !lk[pe_blk][0];
      lock_err <= pe_req &&  lk[pe_blk][0];
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    wire hit = act && (cmd_blk == BW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lk[g] <= 2'b01;
      else if (hit) begin
        case (cmd_data)
          OP_LOCK: lk[g] <= {lk[g][1], 1'b1};
          OP_PIN:  lk[g] <= 2'b11;
          OP_FREE: if (!lk[g][1]) lk[g] <= 2'b00;
          default: lk[g] <= lk[g];
        endcase
      end
    end
  end
endmodule

module blk_lock_ctrl_chk #(
  parameter int NBLK = 16,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [7:0]    cmd_data,
  input logic [BW-1:0] cmd_blk,
  input logic          pe_req,
  input logic [BW-1:0] pe_blk,
  input logic [1:0]    qry_code,
  input logic          qry_wp,
  input logic          pe_ok,
  input logic          lock_err,
  input logic          seq_err,
  input logic          armed,
  input logic [1:0]    lk [NBLK]
);
  wire bad_op = armed && cmd_we && cmd_data != 8'h01 && cmd_data != 8'hD0 && cmd_data != 8'h2F;

  a_r6_bad_action: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> seq_err);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(armed && cmd_we));
  a_r4_lockdown: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_we && cmd_data == 8'h2F) |=> lk[$past(cmd_blk)] == 2'b11);
  a_r5_pinned_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_we && cmd_data == 8'hD0 && lk[cmd_blk] == 2'b11) |=> lk[$past(cmd_blk)] == 2'b11);
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && lk[pe_blk][0]) |=> (lock_err && !pe_ok));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_err && pe_ok));
  a_r10_pinned_protects: assert property (@(posedge clk) disable iff (!rst_n)
    qry_code[1] |-> qry_wp);
endmodule

bind blk_lock_ctrl blk_lock_ctrl_chk #(.NBLK(NBLK), .BW(BW)) u_chk (.*);

// File: tb/blk_lock_ctrl_tb_top.sv
module blk_lock_ctrl_tb_top;
  localparam int NBLK = 16;
  localparam int BW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, pe_req = 0;
  logic [7:0] cmd_data = 0;
  logic [BW-1:0] cmd_blk = 0, pe_blk = 0, qry_blk = 0;
  logic [1:0] qry_code;
  logic qry_wp, pe_ok, lock_err, seq_err;

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_lk [NBLK];
  bit m_arm;

  always #4 clk = ~clk;

  blk_lock_ctrl #(.NBLK(NBLK)) dut_i (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(logic [7:0] d, bit arm, logic [1:0] st);
    if (!arm) return (d == 8'h60) ? "R7" : "R7";
    case (d)
      8'h01: return "R2";
      8'hD0: return st[1] ? "R5" : "R3";
      8'h2F: return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [1:0] next_state(logic [1:0] st, logic [7:0] d);
    case (d)
      8'h01: return {st[1], 1'b1};
      8'h2F: return 2'b11;
      8'hD0: return st[1] ? st : 2'b00;
      default: return st;
    endcase
  endfunction

  task automatic step(bit we, logic [7:0] d, int blk, bit pr, int pb);
    bit exp_seq, exp_ok, exp_err;
    string t;
    @(negedge clk);
    cmd_we = we; cmd_data = d; cmd_blk = BW'(blk);
    pe_req = pr; pe_blk = BW'(pb); qry_blk = BW'(blk);
    exp_seq = we && m_arm && !(d == 8'h01 || d == 8'hD0 || d == 8'h2F);
    exp_ok  = pr && !m_lk[pb][0];
    exp_err = pr &&  m_lk[pb][0];
    t = tag_for(d, m_arm, m_lk[blk]);
    @(posedge clk); #1;
    cmd_we = 0; pe_req = 0;
    check("R9/R8 pe_ok", int'(pe_ok), int'(exp_ok));
    check("R9/R8 lock_err", int'(lock_err), int'(exp_err));
    check("R6 seq_err", int'(seq_err), int'(exp_seq));
    if (we) begin
      if (m_arm) m_lk[blk] = next_state(m_lk[blk], d);
      m_arm = !m_arm && d == 8'h60;
    end
    check(t, int'(qry_code), int'(m_lk[blk]));
    check("R10 qry_wp", int'(qry_wp), int'(m_lk[blk][0]));
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1a0c));
    for (int i = 0; i < NBLK; i++) m_lk[i] = 2'b01;
    m_arm = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NBLK; i++) begin
      qry_blk = BW'(i); #1;
      check("R1 reset code", int'(qry_code), 1);
    end
    rst_n = 1;

    step(1, 8'h60, 3, 0, 0); step(1, 8'hD0, 3, 0, 0);
    step(0, 0, 3, 1, 3);
    step(1, 8'h60, 3, 0, 0); step(1, 8'h01, 3, 1, 3);
    step(1, 8'h60, 5, 0, 0); step(1, 8'h2F, 5, 0, 0);
    step(1, 8'h60, 5, 0, 0); step(1, 8'hD0, 5, 1, 5);
    step(1, 8'h60, 5, 0, 0); step(1, 8'h01, 5, 0, 0);
    step(1, 8'h60, 7, 0, 0); step(1, 8'h60, 7, 0, 0);
    step(1, 8'hD0, 7, 0, 0);
    step(1, 8'h01, 7, 0, 0);
    step(1, 8'h60, 9, 0, 0); step(1, 8'hD0, 9, 1, 9);
    step(0, 0, 9, 1, 9);
    step(1, 8'h60, 9, 0, 0); step(1, 8'h2F, 9, 1, 9);
    step(1, 8'h60, 0, 0, 0); step(1, 8'hFF, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] d;
      int b = $urandom_range(0, NBLK-1);
      int pb = ($urandom_range(0, 1) != 0) ? b : $urandom_range(0, NBLK-1);
      case (r)
        0, 1, 2, 3: d = 8'h60;
        4: d = 8'h01;
        5, 6: d = 8'hD0;
        7: d = 8'h2F;
        default: d = 8'($urandom_range(0, 255));
      endcase
      step($urandom_range(0, 4) != 0, d, b, $urandom_range(0, 1) != 0, pb);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule